// File: doc/BRIEF.md
# Quadrature NCO and Complex Mixer

This block is the tuning front end of a digital downconverter. Real signed samples from an A/D converter arrive one per clock, each qualified by a valid flag. A numerically controlled oscillator turns a phase accumulator into a quadrature pair, a cosine and a sine, through a lookup table. One multiplier forms I as the sample times the cosine, and a second forms Q as the same sample times the sine. When the oscillator is tuned to the centre frequency of a band, that band comes out centred on 0 Hz in the complex I/Q stream.

The only tuning control is the per-sample phase increment. A write loads it, and it takes effect on the next sample without disturbing the running phase. The sine/cosine table is computed inside the RTL. A parameter picks either a full-period table or a quarter-wave table with symmetry folding. Both give identical values.

Top module: `nco_mixer`

## Requirements
- R1: While reset is asserted, and after it, `iq_valid`, `i_out` and `q_out` are 0. The phase accumulator and the stored increment both start at 0.
- R2: The 32-bit phase accumulator adds the stored increment, modulo 2^32, once for every sample accepted with `smp_valid` high. On cycles with `smp_valid` low it holds its value.
- R3: A write with `tune_wr` high stores `tune_word`. A sample accepted in the same cycle as the write still uses the old increment to advance the phase. The first sample that moves the phase by the new value is the next accepted sample. A write never resets the phase.
- R4: The table address is accumulator bits [31:22], taken before the sample's own advance. For address a, the cosine is round(32767·cos(2πa/1024)) and the sine is round(32767·sin(2πa/1024)), with halves rounded away from zero.
- R5: `i_out` = sat16((x·cos + 2^14) >>> 15) and `q_out` = sat16((x·sin + 2^14) >>> 15). Here x is the signed 16-bit sample, >>> is an arithmetic shift and sat16 clamps to [-32768, 32767].
- R6: Every sample accepted at a clock edge produces exactly one output. `iq_valid` is high for that output three clock edges later. No output appears without an input.
- R7: While `iq_valid` is low, `i_out` and `q_out` keep their previous values.
- R8: Suppose the input is a tone whose frequency equals increment/2^32 of the sample rate and whose phase matches the oscillator phase. Over a whole number of tone periods, I then averages to half the tone amplitude and Q averages to zero.
- R9: The quarter-wave table option produces outputs identical, cycle for cycle, to the full-period table option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample qualifier |
| smp_data | input | 16 | Signed A/D sample |
| tune_wr | input | 1 | Load strobe for the phase increment |
| tune_word | input | 32 | New phase increment |
| iq_valid | output | 1 | Output sample qualifier |
| i_out | output | 16 | In-phase product, rounded and saturated |
| q_out | output | 16 | Quadrature product, rounded and saturated |

## Verification
Some properties are checked on every cycle by the assertions. These are the fixed three-edge valid latency, held outputs while no result is valid, a frozen accumulator on idle cycles, a stored increment that changes only on writes, and table pairs whose squared magnitude stays within rounding distance of the full-scale value. Other properties can only be shown by the bench's scenarios against an arithmetic model of phase, table and rounding. These are the exact table values at every one of the 1024 addresses, the exact rounded products at both extremes of the input range, phase continuity across increment writes, the down-conversion of a matched tone to DC, and the agreement of the two table variants.

// File: rtl/nco_mixer_pkg.sv
package nco_mixer_pkg;

   typedef enum logic {
      LUT_FULL    = 1'b0,
      LUT_QUARTER = 1'b1
   } lut_style_e;

   localparam real TWO_PI = 6.283185307179586;

   // Amplitude-scaled cosine or sine of step k out of n steps per period,
   // rounded half away from zero.
   function automatic int tone_round(int k, int n, int amp, bit sine);
      real ang;
      real v;
      ang = TWO_PI * real'(k) / real'(n);
      if (sine) v = real'(amp) * $sin(ang);
      else      v = real'(amp) * $cos(ang);
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(0.5 - v);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  logic               ld,
   input  logic [PHASE_W-1:0] ld_word,
   output logic [ADDR_W-1:0]  phase_msb
);

   logic [PHASE_W-1:0] inc_q;
   logic [PHASE_W-1:0] acc_q;

   if (ADDR_W > PHASE_W) begin : g_chk_w
      $error("nco_phase_acc: ADDR_W must not exceed PHASE_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inc_q <= '0;
         acc_q <= '0;
      end else begin
         if (ld)  inc_q <= ld_word;
         if (adv) acc_q <= acc_q + inc_q;
      end
   end

   assign phase_msb = acc_q[PHASE_W-1 -: ADDR_W];

   AST_INC_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(inc_q)); // R3

   AST_ACC_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(acc_q)); // R2

endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut
   import nco_mixer_pkg::*;
#(
   parameter int         ADDR_W = 10,
   parameter int         OUT_W  = 16,
   parameter lut_style_e STYLE  = LUT_FULL
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [ADDR_W-1:0]        addr,
   output logic signed [OUT_W-1:0]  cos_o,
   output logic signed [OUT_W-1:0]  sin_o
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int AMP   = (1 << (OUT_W - 1)) - 1;

   logic signed [OUT_W-1:0] cos_c;
   logic signed [OUT_W-1:0] sin_c;

   if (ADDR_W < 3) begin : g_chk_addr
      $error("nco_sincos_lut: ADDR_W must be at least 3");
   end
   if (OUT_W < 4 || OUT_W > 30) begin : g_chk_out
      $error("nco_sincos_lut: OUT_W out of range");
   end

   if (STYLE == LUT_FULL) begin : g_full
      logic signed [OUT_W-1:0] cos_rom [DEPTH];
      logic signed [OUT_W-1:0] sin_rom [DEPTH];
      for (genvar k = 0; k < DEPTH; k++) begin : g_ent
         assign cos_rom[k] = OUT_W'(tone_round(k, DEPTH, AMP, 1'b0));
         assign sin_rom[k] = OUT_W'(tone_round(k, DEPTH, AMP, 1'b1));
      end
      always_comb begin
         cos_c = cos_rom[addr];
         sin_c = sin_rom[addr];
      end
   end else begin : g_quarter
      localparam int QN  = 1 << (ADDR_W - 2);
      localparam int QIW = ADDR_W - 1;
      logic signed [OUT_W-1:0] qrom [QN+1];
      logic [1:0]              quad;
      logic [QIW-1:0]          m_fw;
      logic [QIW-1:0]          m_rv;
      for (genvar k = 0; k <= QN; k++) begin : g_ent
         assign qrom[k] = OUT_W'(tone_round(k, DEPTH, AMP, 1'b0));
      end
      always_comb begin
         quad = addr[ADDR_W-1 -: 2];
         m_fw = {1'b0, addr[ADDR_W-3:0]};
         m_rv = QIW'(QN) - m_fw;
         unique case (quad)
            2'd0: begin cos_c =  qrom[m_fw]; sin_c =  qrom[m_rv]; end
            2'd1: begin cos_c = -qrom[m_rv]; sin_c =  qrom[m_fw]; end
            2'd2: begin cos_c = -qrom[m_fw]; sin_c = -qrom[m_rv]; end
            default: begin cos_c = qrom[m_rv]; sin_c = -qrom[m_fw]; end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cos_o <= '0;
         sin_o <= '0;
      end else if (en) begin
         cos_o <= cos_c;
         sin_o <= sin_c;
      end
   end

   // Squared magnitude of a read pair stays within rounding distance of AMP^2.
   logic   loaded_q;
   longint mag2_dev;
   always_ff @(posedge clk) begin
      if (!rst_n)  loaded_q <= 1'b0;
      else if (en) loaded_q <= 1'b1;
   end
   always_comb mag2_dev = longint'(cos_o) * longint'(cos_o)
                        + longint'(sin_o) * longint'(sin_o)
                        - longint'(AMP) * longint'(AMP);

   AST_LUT_QUADRATURE: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q |-> (mag2_dev <= 2 * longint'(AMP) && mag2_dev >= -2 * longint'(AMP))); // R4

endmodule

// File: rtl/nco_mul_rs.sv
module nco_mul_rs #(
   parameter int A_W   = 16,
   parameter int B_W   = 16,
   parameter int O_W   = 16,
   parameter int SHIFT = 15
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en_mul,
   input  logic                   en_out,
   input  logic signed [A_W-1:0]  a,
   input  logic signed [B_W-1:0]  b,
   output logic signed [O_W-1:0]  y
);

   localparam int P_W = A_W + B_W;
   localparam logic signed [P_W:0] HALF = (P_W+1)'(1) <<< (SHIFT - 1);
   localparam logic signed [P_W:0] OMAX = {{(P_W-O_W+2){1'b0}}, {(O_W-1){1'b1}}};
   localparam logic signed [P_W:0] OMIN = {{(P_W-O_W+2){1'b1}}, {(O_W-1){1'b0}}};

   if (SHIFT < 1 || SHIFT >= P_W) begin : g_chk_shift
      $error("nco_mul_rs: SHIFT out of range");
   end
   if (O_W > P_W) begin : g_chk_ow
      $error("nco_mul_rs: O_W wider than the product");
   end

   logic signed [P_W-1:0] prod_q;
   logic signed [P_W:0]   rnd;
   logic signed [O_W-1:0] sat;

   always_comb begin
      rnd = ($signed({prod_q[P_W-1], prod_q}) + HALF) >>> SHIFT;
      if (rnd > OMAX)      sat = OMAX[O_W-1:0];
      else if (rnd < OMIN) sat = OMIN[O_W-1:0];
      else                 sat = rnd[O_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_q <= '0;
         y      <= '0;
      end else begin
         if (en_mul) prod_q <= a * b;
         if (en_out) y      <= sat;
      end
   end

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
   import nco_mixer_pkg::*;
#(
   parameter int         PHASE_W   = 32,
   parameter int         ADDR_W    = 10,
   parameter int         DATA_W    = 16,
   parameter int         LO_W      = 16,
   parameter int         OUT_W     = 16,
   parameter lut_style_e LUT_STYLE = LUT_FULL
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic [DATA_W-1:0]    smp_data,
   input  logic                 tune_wr,
   input  logic [PHASE_W-1:0]   tune_word,
   output logic                 iq_valid,
   output logic [OUT_W-1:0]     i_out,
   output logic [OUT_W-1:0]     q_out
);

   localparam int SHIFT = LO_W - 1;
   localparam int NCH   = 2;

   logic [ADDR_W-1:0]       lut_addr;
   logic signed [LO_W-1:0]  lo_cos;
   logic signed [LO_W-1:0]  lo_sin;
   logic signed [DATA_W-1:0] x_q;
   logic                    v1_q;
   logic                    v2_q;
   logic                    v3_q;

   nco_phase_acc #(
      .PHASE_W (PHASE_W),
      .ADDR_W  (ADDR_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (smp_valid),
      .ld        (tune_wr),
      .ld_word   (tune_word),
      .phase_msb (lut_addr)
   );

   nco_sincos_lut #(
      .ADDR_W (ADDR_W),
      .OUT_W  (LO_W),
      .STYLE  (LUT_STYLE)
   ) u_lut (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (smp_valid),
      .addr  (lut_addr),
      .cos_o (lo_cos),
      .sin_o (lo_sin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q  <= '0;
         v1_q <= 1'b0;
         v2_q <= 1'b0;
         v3_q <= 1'b0;
      end else begin
         if (smp_valid) x_q <= $signed(smp_data);
         v1_q <= smp_valid;
         v2_q <= v1_q;
         v3_q <= v2_q;
      end
   end

   logic signed [LO_W-1:0]  lo_sel [NCH];
   logic signed [OUT_W-1:0] ch_out [NCH];
   assign lo_sel[0] = lo_cos;
   assign lo_sel[1] = lo_sin;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      nco_mul_rs #(
         .A_W   (DATA_W),
         .B_W   (LO_W),
         .O_W   (OUT_W),
         .SHIFT (SHIFT)
      ) u_mul (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_mul (v1_q),
         .en_out (v2_q),
         .a      (x_q),
         .b      (lo_sel[c]),
         .y      (ch_out[c])
      );
   end

   assign iq_valid = v3_q;
   assign i_out    = ch_out[0];
   assign q_out    = ch_out[1];

   // Cycles since reset, saturating, so $past never reaches before reset.
   logic [1:0] since_rst_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                  since_rst_q <= 2'd0;
      else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q == 2'd3) |-> (iq_valid == $past(smp_valid, 3))); // R6

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !iq_valid |-> ($stable(i_out) && $stable(q_out))); // R7

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
      !rst_n |=> (!iq_valid && i_out == '0 && q_out == '0)); // R1

endmodule

// File: tb/tb_nco_mixer.sv
module tb_nco_mixer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic        tune_wr = 1'b0;
   logic [31:0] tune_word = '0;
   logic        iq_valid, qw_valid;
   logic [15:0] i_out, q_out, qw_i, qw_q;

   always #5 clk = ~clk;

   nco_mixer dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .tune_wr(tune_wr), .tune_word(tune_word),
      .iq_valid(iq_valid), .i_out(i_out), .q_out(q_out));

   nco_mixer #(.LUT_STYLE(nco_mixer_pkg::LUT_QUARTER)) dut_qw (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .tune_wr(tune_wr), .tune_word(tune_word),
      .iq_valid(qw_valid), .i_out(qw_i), .q_out(qw_q));

   int checks = 0;
   int fails  = 0;
   int edges  = 0;
   bit done   = 1'b0;
   bit mon_on = 1'b0;

   always @(posedge clk) edges <= edges + 1;

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Table value from R4: round half away from zero of 32767*cos/sin.
   function automatic int lutv(int a, bit s);
      real ang, v;
      ang = 6.283185307179586 * real'(a) / 1024.0;
      v = 32767.0 * (s ? $sin(ang) : $cos(ang));
      if (v >= 0.0) return $rtoi(v + 0.5);
      return -$rtoi(0.5 - v);
   endfunction

   // Rounding and saturation from R5.
   function automatic int rsat(longint p);
      longint r;
      r = (p + 64'sd16384) >>> 15;
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return int'(r);
   endfunction

   logic [31:0] m_acc = '0;
   logic [31:0] m_inc = '0;
   int    exp_i[$], exp_q[$], exp_e[$];
   string exp_tag[$];
   longint dc_sum_i = 0, dc_sum_q = 0;
   int     dc_n = 0;

   task automatic drive(bit v, int x, bit wr, logic [31:0] w, string tag);
      int a;
      @(negedge clk);
      smp_valid = v;
      smp_data  = x[15:0];
      tune_wr   = wr;
      tune_word = w;
      if (v) begin
         a = int'(m_acc[31:22]);
         exp_i.push_back(rsat(longint'(x) * lutv(a, 1'b0)));
         exp_q.push_back(rsat(longint'(x) * lutv(a, 1'b1)));
         exp_e.push_back(edges + 3);
         exp_tag.push_back(tag);
         m_acc = m_acc + m_inc;   // R2: the old increment advances this sample
      end
      if (wr) m_inc = w;          // R3: new increment applies from the next sample
   endtask

   logic [15:0] last_i = '0, last_q = '0;

   always @(negedge clk) begin
      if (mon_on && !done) begin
         // R9: the quarter-wave variant matches the full table
         check(qw_valid == iq_valid && qw_i == i_out && qw_q == q_out, "R9",
               longint'($signed(qw_i)), longint'($signed(i_out)));
         if (iq_valid) begin
            if (exp_i.size() == 0) begin
               check(1'b0, "R6 spurious output", 1, 0);
            end else begin
               string t;
               int ei, eq, ee;
               ei = exp_i.pop_front();
               eq = exp_q.pop_front();
               ee = exp_e.pop_front();
               t  = exp_tag.pop_front();
               check(edges == ee, "R6 latency", edges, ee);
               if (t == "R8") begin
                  dc_sum_i += longint'($signed(i_out));
                  dc_sum_q += longint'($signed(q_out));
                  dc_n++;
               end else begin
                  check(int'($signed(i_out)) == ei, {t, " I"}, longint'($signed(i_out)), ei);
                  check(int'($signed(q_out)) == eq, {t, " Q"}, longint'($signed(q_out)), eq);
               end
            end
         end else begin
            // R7: outputs hold while no result is valid
            check(i_out == last_i && q_out == last_q, "R7 hold",
                  longint'($signed(i_out)), longint'($signed(last_i)));
         end
         last_i = i_out;
         last_q = q_out;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int a0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: outputs quiet while in reset
      check(iq_valid == 1'b0, "R1 valid", iq_valid, 0);
      check(i_out == '0 && q_out == '0, "R1 data", longint'($signed(i_out)), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(iq_valid == 1'b0 && i_out == '0, "R1 after reset", longint'($signed(i_out)), 0);
      mon_on = 1'b1;

      // R1/R5: zero increment, phase 0 -> cos 32767, sin 0
      drive(1, 20000, 0, 0, "R1");
      drive(1, -32768, 0, 0, "R5");

      // R4/R5: walk every table address with extreme and random samples
      drive(0, 0, 1, 32'h0040_0000, "R4");
      for (int k = 0; k < 1024; k++) drive(1, 32767, 0, 0, "R4");
      for (int k = 0; k < 1024; k++) drive(1, -32768, 0, 0, "R5");
      for (int k = 0; k < 1024; k++) drive(1, int'($urandom % 65536) - 32768, 0, 0, "R5");

      // R2: fractional increment with gaps in the valid stream
      drive(0, 0, 1, 32'h0123_4567, "R2");
      for (int k = 0; k < 900; k++)
         drive(k % 3 == 0, int'($urandom % 65536) - 32768, 0, 0, "R2");

      // R3: increment writes while samples flow, including same-cycle writes
      for (int k = 0; k < 400; k++) begin
         bit wr;
         wr = (k % 37 == 5);
         drive(1, int'($urandom % 65536) - 32768, wr, $urandom, "R3");
      end
      drive(1, 12345, 1, 32'hFFC0_0000, "R3");
      for (int k = 0; k < 50; k++) drive(1, 12345, 0, 0, "R3");

      // R8: matched tone down-converted to DC
      drive(0, 0, 1, 32'd37 << 22, "R8");
      a0 = int'(m_acc[31:22]);
      for (int n = 0; n < 1024; n++) begin
         real v;
         int xv;
         v = 20000.0 * $cos(6.283185307179586 * real'((a0 + 37 * n) % 1024) / 1024.0);
         xv = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
         drive(1, xv, 0, 0, "R8");
      end

      for (int k = 0; k < 10; k++) drive(0, 0, 0, 0, "idle");
      @(negedge clk);
      check(exp_i.size() == 0, "R6 all outputs delivered", exp_i.size(), 0);
      check(dc_n == 1024, "R8 count", dc_n, 1024);
      check(dc_sum_i / 1024 >= 9980 && dc_sum_i / 1024 <= 10020, "R8 I mean",
            dc_sum_i / 1024, 10000);
      check(dc_sum_q / 1024 >= -20 && dc_sum_q / 1024 <= 20, "R8 Q mean",
            dc_sum_q / 1024, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule